// File: doc/BRIEF.md
# Multi-Link Event Builder with Trigger Throttle

This block collects the per-event fragments returned by a set of front-end readout links and assembles each triggered event into one record. The record leaves as a stream of 32-bit words over a valid/ready interface. Each link has its own word decoder and its own fragment FIFO. A single merge sequencer walks the links in index order for every pending trigger. The block raises a busy output when any FIFO fills past a high-water mark, so that the upstream trigger source holds further triggers.

Links misbehave in practice. Some return nothing, some return more words than allowed, and some return words that cannot be decoded or that carry the wrong event counter. None of these may stall the block. A silent link is closed by a per-slot timeout. A long fragment is cut at a fixed word limit. Undecodable words are dropped and flagged. An old fragment left over from an earlier timeout is thrown away. A fragment from a later event is merged but marked. Every fault shows up in the record, both per fragment and in the event trailer.

A link word is 18 bits: kind in [17:16] (01 fragment header, 10 data, 11 fragment trailer, 00 illegal) and payload in [15:0]. A fragment header carries the event counter in its payload.

Top module: `evb_event_builder`

## Requirements
- R1: For each trigger the output carries one record: a header word `{4'hA, 12'h0, event[15:0]}`, then one fragment per link in ascending link order, then a trailer word. The event number starts at 0 after reset and goes up by one per record. A new header follows a trailer only after at least one cycle with out_valid low.
- R2: Each data word of a fragment is sent as `{4'hD, 12'h0, payload}` in arrival order. Each fragment closes with an end word `{4'hF, 4'h0, link[7:0], 12'h0, flags[3:0]}`. Every output word carries one of the tags A, D, F or E in bits [31:28].
- R3: A link slot that sees its FIFO empty for TMO_CYC cycles is closed with an end word that has flag bit 0 (timeout) set and carries no data. The merge then moves on to the next link.
- R4: A fragment with more than MAX_WORDS data words keeps its first MAX_WORDS words. The rest are dropped up to the fragment trailer, and flag bit 1 (truncated) is set.
- R5: A fragment whose header counter is ahead of the current event number is merged with flag bit 2 (desync) set.
- R6: A fragment whose header counter is behind the current event number (by 1 to 32767, modulo 2^16) is discarded whole. The slot keeps waiting for the right fragment.
- R7: An illegal word (kind 00) inside a fragment is dropped and sets flag bit 3 (garbled). A fragment header that arrives inside a fragment closes the open fragment with the garbled flag.
- R8: The trailer word is `{4'hE, 12'h0, bitmap}`. Bit i of the bitmap is set when the end word of link i had any flag set.
- R9: busy rises only in the cycle after some FIFO level exceeds HI_MARK.
- R10: busy falls only in the cycle after all FIFO levels are below LO_MARK. Between the two marks it keeps its value, and it returns to 0 once the FIFOs drain.
- R11: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R12: Words that reach a FIFO while no trigger is pending and the sequencer is idle are discarded and never appear in a later record.
- R13: After reset busy and out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | One-cycle trigger pulse; each pulse requests one record |
| link_valid_i | input | N_LINKS | Per-link word strobe |
| link_word_i | input | 18*N_LINKS | Per-link words, link i at bits [18i+17:18i] |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Output record word |
| out_ready_i | input | 1 | Downstream accepts the word |
| busy_o | output | 1 | Trigger throttle |

The sequencer states are IDLE (no trigger pending; stray FIFO words are drained), HEAD (event header offered), SLOT (waiting for a fragment header on the current link), COPY (data words forwarded), SKIP (stale fragment discarded), FEND (end word offered) and TAIL (trailer offered). The transitions are as follows:
- IDLE→HEAD on a pending trigger.
- HEAD→SLOT on accept.
- SLOT→COPY on a matching or ahead header.
- SLOT→SKIP on a stale header.
- SKIP→SLOT on that fragment's trailer.
- SLOT, COPY or SKIP→FEND on timeout.
- COPY→FEND on a trailer or a stray header.
- FEND→SLOT for the next link.
- FEND→TAIL after the last link.
- TAIL→IDLE on accept.

## Verification
On every cycle, the assertions check the busy hysteresis against the FIFO levels, the holding of a stalled output word, the legality of word tags, and the idle gap between one record's trailer and the next header. Only the bench scenarios can show the rest:
- records assembled correctly from well-formed fragments;
- the timeout closing of a silent link;
- truncation of an oversized fragment;
- the garbled and desync flags and the trailer bitmap;
- silent discarding of a stale fragment left over after a timeout;
- discarding of unsolicited words while idle;
- busy clearing after a long output stall, with every triggered event closed.

// File: rtl/evb_pkg.sv
package evb_pkg;
    localparam int LW = 18;

    typedef enum logic [1:0] {
        K_BAD  = 2'b00,
        K_HEAD = 2'b01,
        K_DATA = 2'b10,
        K_TAIL = 2'b11
    } kind_e;

    localparam int F_TMO    = 0;
    localparam int F_TRUNC  = 1;
    localparam int F_DESYNC = 2;
    localparam int F_GARB   = 3;

    localparam logic [3:0] TAG_EVH  = 4'hA;
    localparam logic [3:0] TAG_DAT  = 4'hD;
    localparam logic [3:0] TAG_FEND = 4'hF;
    localparam logic [3:0] TAG_EVT  = 4'hE;
endpackage

// File: rtl/evb_link_decoder.sv
module evb_link_decoder
    import evb_pkg::*;
#(
    parameter int MAX_WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [LW-1:0] in_word,
    output logic          wr_en,
    output logic [LW-1:0] wr_word
);
    localparam int CW = $clog2(MAX_WORDS + 1);
    localparam logic [CW-1:0] CAP = CW'(MAX_WORDS);

    typedef enum logic [1:0] {L_HUNT, L_BODY, L_DROP} lstate_e;

    lstate_e       st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          trunc_q, trunc_d, garb_q, garb_d;
    kind_e         kind;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= L_HUNT;
            cnt_q   <= '0;
            trunc_q <= 1'b0;
            garb_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            trunc_q <= trunc_d;
            garb_q  <= garb_d;
        end
    end

    always_comb begin
        kind    = kind_e'(in_word[17:16]);
        st_d    = st_q;
        cnt_d   = cnt_q;
        trunc_d = trunc_q;
        garb_d  = garb_q;
        wr_en   = 1'b0;
        wr_word = in_word;
        unique case (st_q)
            L_HUNT: begin
                if (in_valid && kind == K_HEAD) begin
                    wr_en   = 1'b1;
                    cnt_d   = '0;
                    trunc_d = 1'b0;
                    garb_d  = 1'b0;
                    st_d    = L_BODY;
                end
            end
            L_BODY, L_DROP: begin
                if (in_valid) begin
                    case (kind)
                        K_DATA: begin
                            if (st_q == L_BODY) begin
                                if (cnt_q < CAP) begin
                                    wr_en = 1'b1;
                                    cnt_d = cnt_q + 1'b1;
                                end else begin
                                    trunc_d = 1'b1;
                                    st_d    = L_DROP;
                                end
                            end
                        end
                        K_BAD: garb_d = 1'b1;
                        K_TAIL: begin
                            wr_en   = 1'b1;
                            wr_word = {K_TAIL, 12'h0, garb_q, 1'b0, trunc_q, 1'b0};
                            st_d    = L_HUNT;
                        end
                        K_HEAD: begin
                            wr_en   = 1'b1;
                            wr_word = {K_TAIL, 12'h0, 1'b1, 1'b0, trunc_q, 1'b0};
                            st_d    = L_HUNT;
                        end
                    endcase
                end
            end
            default: st_d = L_HUNT;
        endcase
    end
endmodule

// File: rtl/evb_frag_fifo.sv
module evb_frag_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 16,
    localparam int LVW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [W-1:0]   wr_data,
    input  logic           rd_en,
    output logic [W-1:0]   rd_data,
    output logic           empty,
    output logic [LVW-1:0] level
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]   mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic [LVW-1:0] cnt;
    logic           do_wr, do_rd;

    assign do_wr   = wr_en && (cnt != LVW'(DEPTH));
    assign do_rd   = rd_en && (cnt != '0);
    assign rd_data = mem[rp];
    assign empty   = (cnt == '0);
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            cnt <= cnt + LVW'(do_wr) - LVW'(do_rd);
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end
endmodule

// File: rtl/evb_merger.sv
module evb_merger
    import evb_pkg::*;
#(
    parameter int N_LINKS = 4,
    parameter int TMO_CYC = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       trig,
    input  logic [N_LINKS-1:0][LW-1:0] head,
    input  logic [N_LINKS-1:0]         empty,
    output logic [N_LINKS-1:0]         pop,
    output logic                       out_valid,
    output logic [31:0]                out_data,
    input  logic                       out_ready
);
    localparam int LIDW = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;
    localparam int TW   = $clog2(TMO_CYC + 1);

    typedef enum logic [2:0] {M_IDLE, M_HEAD, M_SLOT, M_COPY, M_SKIP, M_FEND, M_TAIL} mstate_e;

    mstate_e            st_q, st_d;
    logic [LIDW-1:0]    link_q, link_d;
    logic [TW-1:0]      tmr_q, tmr_d;
    logic [3:0]         flags_q, flags_d;
    logic [N_LINKS-1:0] bmap_q, bmap_d;
    logic [15:0]        evt_q, evt_d, diff, bmap_ext;
    logic [7:0]         pend_q, pend_d;
    logic [LW-1:0]      cur;
    logic               cur_empty, tmo_hit;
    kind_e              kind;

    assign cur       = head[link_q];
    assign cur_empty = empty[link_q];
    assign kind      = kind_e'(cur[17:16]);
    assign diff      = evt_q - cur[15:0];
    assign tmo_hit   = (tmr_q == TW'(TMO_CYC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= M_IDLE;
            link_q  <= '0;
            tmr_q   <= '0;
            flags_q <= '0;
            bmap_q  <= '0;
            evt_q   <= '0;
            pend_q  <= '0;
        end else begin
            st_q    <= st_d;
            link_q  <= link_d;
            tmr_q   <= tmr_d;
            flags_q <= flags_d;
            bmap_q  <= bmap_d;
            evt_q   <= evt_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        link_d  = link_q;
        tmr_d   = tmr_q;
        flags_d = flags_q;
        bmap_d  = bmap_q;
        evt_d   = evt_q;
        pop     = '0;
        pend_d  = pend_q + {7'b0, trig} - {7'b0, (st_q == M_TAIL) && out_ready};
        unique case (st_q)
            M_IDLE: begin
                if (pend_q != '0) st_d = M_HEAD;
                else              pop  = ~empty;
            end
            M_HEAD: begin
                if (out_ready) begin
                    st_d    = M_SLOT;
                    link_d  = '0;
                    tmr_d   = '0;
                    flags_d = '0;
                    bmap_d  = '0;
                end
            end
            M_SLOT, M_COPY, M_SKIP: begin
                if (cur_empty) begin
                    if (tmo_hit) begin
                        flags_d[F_TMO] = 1'b1;
                        st_d           = M_FEND;
                    end else begin
                        tmr_d = tmr_q + 1'b1;
                    end
                end else if (st_q == M_SLOT) begin
                    pop[link_q] = 1'b1;
                    if (kind == K_HEAD) begin
                        if (diff == '0) begin
                            st_d = M_COPY;
                        end else if (!diff[15]) begin
                            st_d = M_SKIP;
                        end else begin
                            flags_d[F_DESYNC] = 1'b1;
                            st_d              = M_COPY;
                        end
                    end
                end else if (st_q == M_SKIP) begin
                    pop[link_q] = 1'b1;
                    if (kind == K_TAIL) st_d = M_SLOT;
                end else begin
                    case (kind)
                        K_DATA: pop[link_q] = out_ready;
                        K_TAIL: begin
                            pop[link_q] = 1'b1;
                            flags_d     = flags_q | cur[3:0];
                            st_d        = M_FEND;
                        end
                        K_HEAD: begin
                            flags_d[F_GARB] = 1'b1;
                            st_d            = M_FEND;
                        end
                        K_BAD: pop[link_q] = 1'b1;
                    endcase
                end
            end
            M_FEND: begin
                if (out_ready) begin
                    bmap_d[link_q] = |flags_q;
                    flags_d        = '0;
                    tmr_d          = '0;
                    if (link_q == LIDW'(N_LINKS - 1)) begin
                        st_d = M_TAIL;
                    end else begin
                        link_d = link_q + 1'b1;
                        st_d   = M_SLOT;
                    end
                end
            end
            M_TAIL: begin
                if (out_ready) begin
                    evt_d = evt_q + 1'b1;
                    st_d  = M_IDLE;
                end
            end
            default: st_d = M_IDLE;
        endcase
    end

    always_comb begin
        bmap_ext                = '0;
        bmap_ext[N_LINKS-1:0]   = bmap_q;
        out_valid               = 1'b0;
        out_data                = '0;
        unique case (st_q)
            M_HEAD: begin
                out_valid = 1'b1;
                out_data  = {TAG_EVH, 12'h0, evt_q};
            end
            M_COPY: begin
                out_valid = !cur_empty && (kind == K_DATA);
                out_data  = {TAG_DAT, 12'h0, cur[15:0]};
            end
            M_FEND: begin
                out_valid = 1'b1;
                out_data  = {TAG_FEND, 4'h0, {{(8 - LIDW){1'b0}}, link_q}, 12'h0, flags_q};
            end
            M_TAIL: begin
                out_valid = 1'b1;
                out_data  = {TAG_EVT, 12'h0, bmap_ext};
            end
            default: begin
                out_valid = 1'b0;
                out_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/evb_event_builder.sv
module evb_event_builder
    import evb_pkg::*;
#(
    parameter int N_LINKS    = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int MAX_WORDS  = 4,
    parameter int TMO_CYC    = 40,
    parameter int HI_MARK    = 10,
    parameter int LO_MARK    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig_i,
    input  logic [N_LINKS-1:0]    link_valid_i,
    input  logic [N_LINKS*18-1:0] link_word_i,
    output logic                  out_valid_o,
    output logic [31:0]           out_data_o,
    input  logic                  out_ready_i,
    output logic                  busy_o
);
    localparam int LVW = $clog2(FIFO_DEPTH + 1);

    logic [N_LINKS-1:0][LW-1:0]  fifo_head, dec_word;
    logic [N_LINKS-1:0][LVW-1:0] fifo_level;
    logic [N_LINKS-1:0]          fifo_empty, fifo_pop, dec_wr;
    logic                        any_hi, all_lo, busy_q;

    for (genvar i = 0; i < N_LINKS; i++) begin : g_link
        evb_link_decoder #(.MAX_WORDS(MAX_WORDS)) u_dec (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (link_valid_i[i]),
            .in_word  (link_word_i[i*LW +: LW]),
            .wr_en    (dec_wr[i]),
            .wr_word  (dec_word[i])
        );
        evb_frag_fifo #(.W(LW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (dec_wr[i]),
            .wr_data (dec_word[i]),
            .rd_en   (fifo_pop[i]),
            .rd_data (fifo_head[i]),
            .empty   (fifo_empty[i]),
            .level   (fifo_level[i])
        );
    end

    evb_merger #(.N_LINKS(N_LINKS), .TMO_CYC(TMO_CYC)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig_i),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .pop       (fifo_pop),
        .out_valid (out_valid_o),
        .out_data  (out_data_o),
        .out_ready (out_ready_i)
    );

    always_comb begin
        any_hi = 1'b0;
        all_lo = 1'b1;
        for (int i = 0; i < N_LINKS; i++) begin
            if (fifo_level[i] > LVW'(HI_MARK))  any_hi = 1'b1;
            if (fifo_level[i] >= LVW'(LO_MARK)) all_lo = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b0;
        else if (any_hi) busy_q <= 1'b1;
        else if (all_lo) busy_q <= 1'b0;
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/evb_event_builder_chk.sv
module evb_event_builder_chk #(
    parameter int N_LINKS = 4,
    parameter int LVW     = 5,
    parameter int HI_MARK = 10,
    parameter int LO_MARK = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        busy,
    input logic [N_LINKS-1:0][LVW-1:0] lvl,
    input logic                        out_valid,
    input logic                        out_ready,
    input logic [31:0]                 out_data
);
    logic seen_hi, seen_lo, tag_ok;

    always_comb begin
        seen_hi = 1'b0;
        seen_lo = 1'b1;
        for (int i = 0; i < N_LINKS; i++) begin
            if (int'(lvl[i]) > HI_MARK)   seen_hi = 1'b1;
            if (int'(lvl[i]) >= LO_MARK)  seen_lo = 1'b0;
        end
        tag_ok = (out_data[31:28] == 4'hA) || (out_data[31:28] == 4'hD) ||
                 (out_data[31:28] == 4'hF) || (out_data[31:28] == 4'hE);
    end

    // R9
    a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(seen_hi));

    // R10
    a_r10_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(seen_lo));

    // R11
    a_r11_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R2
    a_r2_tag_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> tag_ok);

    // R1
    a_r1_gap_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_data[31:28] == 4'hE) |=> !out_valid);
endmodule

bind evb_event_builder evb_event_builder_chk #(
    .N_LINKS (N_LINKS),
    .LVW     ($clog2(FIFO_DEPTH + 1)),
    .HI_MARK (HI_MARK),
    .LO_MARK (LO_MARK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_o),
    .lvl       (fifo_level),
    .out_valid (out_valid_o),
    .out_ready (out_ready_i),
    .out_data  (out_data_o)
);

// File: tb/evb_event_builder_bench.sv
`timescale 1ns/1ps
module evb_event_builder_bench;
    localparam int NL = 4;

    logic            clk = 1'b0;
    logic            rst_n, trig, ordy, ov, busy;
    logic [NL-1:0]   lv;
    logic [NL*18-1:0] lw;
    logic [31:0]     od;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] m_exp;
    string       m_tag;

    always #4 clk = ~clk;

    evb_event_builder #(
        .N_LINKS(NL), .FIFO_DEPTH(16), .MAX_WORDS(4),
        .TMO_CYC(40), .HI_MARK(10), .LO_MARK(4)
    ) u_evb_event_builder (
        .clk(clk), .rst_n(rst_n), .trig_i(trig),
        .link_valid_i(lv), .link_word_i(lw),
        .out_valid_o(ov), .out_data_o(od), .out_ready_i(ordy), .busy_o(busy)
    );

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] pay(int e, int l, int j);
        return 16'(e * 4096 + l * 256 + j + 1);
    endfunction

    task automatic expw(logic [31:0] w, string t);
        exp_q.push_back(w);
        tag_q.push_back(t);
    endtask

    task automatic exp_head(int e);
        expw({4'hA, 12'h0, 16'(e)}, "R1 header");
    endtask

    task automatic exp_tail(int b, string t);
        expw({4'hE, 12'h0, 16'(b)}, t);
    endtask

    task automatic exp_link(int l, int e, int n, int f, string t);
        for (int j = 0; j < n; j++) expw({4'hD, 12'h0, pay(e, l, j)}, "R2 data");
        expw({4'hF, 4'h0, 8'(l), 12'h0, 4'(f)}, t);
    endtask

    task automatic put(int l, logic [1:0] k, logic [15:0] p);
        @(negedge clk);
        lv = '0;
        lv[l] = 1'b1;
        lw[l*18 +: 18] = {k, p};
    endtask

    task automatic quiet();
        @(negedge clk);
        lv = '0;
    endtask

    task automatic send_frag(int l, int ec, int e, int n, bit garb);
        put(l, 2'b01, 16'(ec));
        for (int j = 0; j < n; j++) begin
            put(l, 2'b10, pay(e, l, j));
            if (garb && j == 0) put(l, 2'b00, 16'hDEAD);
        end
        put(l, 2'b11, 16'h0);
        quiet();
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic drain(string t);
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, t, 32'(exp_q.size()), 32'h0);
    endtask

    task automatic finish_up();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Scoreboard monitor: compares each accepted word with the queue head.
    always @(negedge clk) begin
        #1;
        if (rst_n && ov && ordy && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected word", od, 32'h0);
            end else begin
                m_exp = exp_q.pop_front();
                m_tag = tag_q.pop_front();
                check(od == m_exp, m_tag, od, m_exp);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 32'h0, 32'h1);
            finish_up();
        end
    end

    initial begin
        rst_n = 1'b0; trig = 1'b0; ordy = 1'b1; lv = '0; lw = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(busy == 1'b0, "R13 busy after reset", 32'(busy), 32'h0);
        check(ov == 1'b0, "R13 out_valid after reset", 32'(ov), 32'h0);

        // Event 0: clean fragments on all links
        exp_head(0);
        for (int l = 0; l < NL; l++) exp_link(l, 0, 2, 0, "R1 end word");
        exp_tail(0, "R8 clean bitmap");
        pulse_trig();
        for (int l = 0; l < NL; l++) send_frag(l, 0, 0, 2, 0);
        drain("R1 event 0 closed");

        // Event 1: link 2 silent -> timeout
        exp_head(1);
        for (int l = 0; l < NL; l++)
            if (l == 2) exp_link(2, 1, 0, 1, "R3 timeout end word");
            else        exp_link(l, 1, 2, 0, "R1 end word");
        exp_tail(4, "R8 timeout bitmap");
        pulse_trig();
        for (int l = 0; l < NL; l++) if (l != 2) send_frag(l, 1, 1, 2, 0);
        drain("R3 event 1 closed");

        // Event 2: link 1 oversized
        exp_head(2);
        for (int l = 0; l < NL; l++)
            if (l == 1) exp_link(1, 2, 4, 2, "R4 truncated end word");
            else        exp_link(l, 2, 2, 0, "R1 end word");
        exp_tail(2, "R8 truncation bitmap");
        pulse_trig();
        for (int l = 0; l < NL; l++) send_frag(l, 2, 2, (l == 1) ? 7 : 2, 0);
        drain("R4 event 2 closed");

        // Event 3: link 3 carries an illegal word
        exp_head(3);
        for (int l = 0; l < NL; l++)
            if (l == 3) exp_link(3, 3, 2, 8, "R7 garbled end word");
            else        exp_link(l, 3, 2, 0, "R1 end word");
        exp_tail(8, "R8 garbled bitmap");
        pulse_trig();
        for (int l = 0; l < NL; l++) send_frag(l, 3, 3, 2, l == 3);
        drain("R7 event 3 closed");

        // Event 4: link 0 ahead (desync), link 2 late fragment of event 1 first
        exp_head(4);
        exp_link(0, 4, 2, 4, "R5 desync end word");
        exp_link(1, 4, 2, 0, "R1 end word");
        exp_link(2, 4, 2, 0, "R6 stale skipped end word");
        exp_link(3, 4, 2, 0, "R1 end word");
        exp_tail(1, "R8 desync bitmap");
        pulse_trig();
        send_frag(0, 9, 4, 2, 0);
        send_frag(1, 4, 4, 2, 0);
        send_frag(2, 1, 15, 2, 0);
        send_frag(2, 4, 4, 2, 0);
        send_frag(3, 4, 4, 2, 0);
        drain("R6 event 4 closed");

        // Events 5 and 6 under output stall: busy
        @(negedge clk);
        ordy = 1'b0;
        for (int e = 5; e <= 6; e++) begin
            exp_head(e);
            for (int l = 0; l < NL; l++) exp_link(l, e, 4, 0, "R1 end word");
            exp_tail(0, "R8 clean bitmap");
        end
        pulse_trig();
        pulse_trig();
        for (int l = 0; l < NL; l++) begin
            send_frag(l, 5, 5, 4, 0);
            send_frag(l, 6, 6, 4, 0);
        end
        @(negedge clk); #1;
        check(busy == 1'b1, "R9 busy over high mark", 32'(busy), 32'h1);
        check(ov && od == {4'hA, 12'h0, 16'd5}, "R11 stalled header held", od,
              {4'hA, 12'h0, 16'd5});
        @(negedge clk);
        ordy = 1'b1;
        drain("R10 stalled events closed");
        repeat (3) @(negedge clk);
        #1;
        check(busy == 1'b0, "R10 busy released after drain", 32'(busy), 32'h0);

        // Event 7: unsolicited words while idle are dropped
        send_frag(1, 7, 14, 2, 0);
        repeat (5) @(negedge clk);
        #1;
        check(ov == 1'b0, "R12 no output while idle", 32'(ov), 32'h0);
        exp_head(7);
        for (int l = 0; l < NL; l++) exp_link(l, 7, 2, 0, "R12 end word");
        exp_tail(0, "R12 clean bitmap");
        pulse_trig();
        for (int l = 0; l < NL; l++) send_frag(l, 7, 7, 2, 0);
        drain("R12 event 7 closed");

        @(negedge clk); #1;
        check(busy == 1'b0, "R10 busy low at end", 32'(busy), 32'h0);
        finish_up();
    end
endmodule